// File: doc/BRIEF.md
# Processor Power Mode Controller

This block is the state machine that decides which operating mode a processor core is in and drives the enables that follow from that mode. Software asks for a mode through a request strobe. The controller then gates the core clock and the system clock and switches the core regulator off or on. In the deepest state it also three-states the external pads. Wake events bring the core back, and which mode it returns to depends on both the mode being left and the source that woke it. The real PLL, the analog regulator and the clock gating cells are outside the block. They appear here only as enable outputs.

The two run modes differ in the PLL: full-on runs from the PLL, and active runs with the PLL bypassed. Sleep stops only the core clock, and deep sleep stops both clocks. Hibernate also removes core power. Leaving hibernate always passes through a timed hardware reset sequence rather than resuming directly. A regulator voltage code register is the only state that survives hibernate and the reset pin.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After power-on reset (rst_n low) the mode is full-on (mode_o = 0). Both clock enables and the regulator enable are high, hw_rst_o and pad_tri_o are all zero, and the voltage code equals VR_RESET.
- R2: In full-on or active, a request with code 0 (full-on), 1 (active), 2 (sleep), 3 (deep sleep) or 4 (hibernate) becomes mode_o one cycle later. Codes 5 to 7 are ignored. pll_bypass_o is high only in active mode.
- R3: In sleep (mode_o = 2) the core clock enable is low while the system clock enable and the regulator enable stay high.
- R4: In sleep, an RTC interrupt or any wake_evt_i bit whose wake_mask_i bit is set samples pll_bypass_i. The next mode is active (1) if it is set and full-on (0) if it is clear. Events with a clear mask bit are ignored.
- R5: A DMA request to L1 made in sleep raises dma_err_o on the following cycle. The same request made in any other mode leaves dma_err_o low.
- R6: In deep sleep (mode_o = 3) both clock enables are low. Peripheral and GPIO wakes are ignored. An RTC interrupt moves to active, and the reset pin moves to full-on and wins over a simultaneous RTC interrupt.
- R7: In hibernate (mode_o = 4) both clocks and the regulator enable are low. Every pad whose pad_exempt_i bit is clear is three-stated (pad_tri_o bit high), and exempt pads stay driven.
- R8: Hibernate is left only by the reset pin, an RTC interrupt or an enabled wake event, and always into the reset sequence (mode_o = 5). Masked events are ignored.
- R9: The reset sequence lasts SETTLE_CYCLES cycles with the regulator enable high, hw_rst_o high and both clocks low, and then enters full-on.
- R10: The voltage code is written only in full-on or active. Its value is kept across hibernate, the reset sequence and the reset pin. core_mv_o = BASE_MV + STEP_MV × code (50 mV per code by default).
- R11: Mode requests made in sleep, deep sleep or hibernate are ignored.
- R12: The reset pin in full-on, active or sleep moves the block to full-on on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| req_valid_i | input | 1 | Mode request strobe |
| req_mode_i | input | 3 | Requested mode code |
| pll_bypass_i | input | 1 | PLL bypass bit sampled on a sleep wake |
| wake_mask_i | input | NUM_WAKE | Per-source wake enable |
| wake_evt_i | input | NUM_WAKE | Peripheral and GPIO wake events |
| rtc_irq_i | input | 1 | RTC wake interrupt |
| rst_pin_i | input | 1 | External reset pin, active high |
| dma_l1_req_i | input | 1 | System DMA request to L1 memory |
| vr_wr_i | input | 1 | Voltage code write strobe |
| vr_wdata_i | input | VR_W | Voltage code write data |
| pad_exempt_i | input | NUM_PADS | Pads kept driven in hibernate |
| mode_o | output | 3 | Current mode (0 full-on, 1 active, 2 sleep, 3 deep sleep, 4 hibernate, 5 reset sequence) |
| cclk_en_o | output | 1 | Core clock enable |
| sclk_en_o | output | 1 | System clock enable |
| vreg_en_o | output | 1 | Core regulator enable |
| pll_bypass_o | output | 1 | PLL bypassed (active mode) |
| hw_rst_o | output | 1 | Internal hardware reset, high during the reset sequence |
| pad_tri_o | output | NUM_PADS | Per-pad three-state control |
| dma_err_o | output | 1 | Refused DMA access flag |
| vr_code_o | output | VR_W | Retained voltage code |
| core_mv_o | output | MV_W | Programmed core voltage in mV |

## Verification
The bench targets the places where the return mode depends on the exit path. A sleep wake must follow the bypass bit as it stands at the wake: a design that latched it earlier, or ignored it, would come back to full-on when it should return to active. A deep sleep that honoured a peripheral event, or let the RTC beat the reset pin, would leave the state early or land in the wrong run mode. A hibernate exit is counted cycle by cycle, so a reset sequence one cycle short or long, or a direct resume, shows up as a wrong mode_o at a known cycle. The voltage code is written during hibernate and then read back after the reset sequence and after the pin reset. A design that cleared it, or accepted writes while powered down, would show a changed value.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

   typedef enum logic [2:0] {
      PM_FULL   = 3'd0,
      PM_ACTIVE = 3'd1,
      PM_SLEEP  = 3'd2,
      PM_DSLEEP = 3'd3,
      PM_HIBER  = 3'd4,
      PM_RSTSEQ = 3'd5
   } pm_state_e;

   localparam logic [2:0] PM_MAX_REQ = 3'd4;

   function automatic logic pm_is_run(input pm_state_e s);
      return (s == PM_FULL) || (s == PM_ACTIVE);
   endfunction

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
#(
   parameter int NUM_WAKE      = 4,
   parameter int SETTLE_CYCLES = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid_i,
   input  logic [2:0]          req_mode_i,
   input  logic                pll_bypass_i,
   input  logic [NUM_WAKE-1:0] wake_mask_i,
   input  logic [NUM_WAKE-1:0] wake_evt_i,
   input  logic                rtc_irq_i,
   input  logic                rst_pin_i,
   input  logic                dma_l1_req_i,
   output pm_state_e           state_o,
   output logic                dma_err_o
);

   localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYCLES - 1);

   pm_state_e        st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             dma_err_q;
   logic             periph_wake;

   assign periph_wake = |(wake_evt_i & wake_mask_i);

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      case (st_q)
         PM_FULL, PM_ACTIVE: begin
            if (rst_pin_i)
               st_d = PM_FULL;
            else if (req_valid_i && (req_mode_i <= PM_MAX_REQ))
               st_d = pm_state_e'(req_mode_i);
         end
         PM_SLEEP: begin
            if (rst_pin_i)
               st_d = PM_FULL;
            else if (periph_wake || rtc_irq_i)
               st_d = pll_bypass_i ? PM_ACTIVE : PM_FULL;
         end
         PM_DSLEEP: begin
            if (rst_pin_i)
               st_d = PM_FULL;
            else if (rtc_irq_i)
               st_d = PM_ACTIVE;
         end
         PM_HIBER: begin
            if (rst_pin_i || rtc_irq_i || periph_wake) begin
               st_d  = PM_RSTSEQ;
               cnt_d = '0;
            end
         end
         PM_RSTSEQ: begin
            if (cnt_q == CNT_LAST)
               st_d = PM_FULL;
            else
               cnt_d = cnt_q + 1'b1;
         end
         default: st_d = PM_FULL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= PM_FULL;
         cnt_q     <= '0;
         dma_err_q <= 1'b0;
      end else begin
         st_q      <= st_d;
         cnt_q     <= cnt_d;
         dma_err_q <= dma_l1_req_i && (st_q == PM_SLEEP);
      end
   end

   assign state_o   = st_q;
   assign dma_err_o = dma_err_q;

endmodule

// File: rtl/pwr_vreg_ctrl.sv
module pwr_vreg_ctrl #(
   parameter int          VR_W     = 6,
   parameter int          MV_W     = 16,
   parameter logic [VR_W-1:0] VR_RESET = 6'd20,
   parameter int          BASE_MV  = 700,
   parameter int          STEP_MV  = 50
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en_i,
   input  logic [VR_W-1:0] wdata_i,
   output logic [VR_W-1:0] code_o,
   output logic [MV_W-1:0] mv_o
);

   localparam logic [MV_W-1:0] BASE = MV_W'(BASE_MV);
   localparam logic [MV_W-1:0] STEP = MV_W'(STEP_MV);

   logic [VR_W-1:0] code_q;

   // Only power-on reset clears this register; it is in the retained domain.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code_q <= VR_RESET;
      else if (wr_en_i)
         code_q <= wdata_i;
   end

   assign code_o = code_q;
   assign mv_o   = BASE + MV_W'(code_q) * STEP;

endmodule

// File: rtl/pwr_pad_iso.sv
module pwr_pad_iso #(
   parameter int NUM_PADS = 8
) (
   input  logic                iso_i,
   input  logic [NUM_PADS-1:0] exempt_i,
   output logic [NUM_PADS-1:0] tri_o
);

   for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
      assign tri_o[p] = iso_i & ~exempt_i[p];
   end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_mode_pkg::*;
#(
   parameter int              NUM_WAKE      = 4,
   parameter int              NUM_PADS      = 8,
   parameter int              VR_W          = 6,
   parameter int              MV_W          = 16,
   parameter logic [VR_W-1:0] VR_RESET      = 6'd20,
   parameter int              BASE_MV       = 700,
   parameter int              STEP_MV       = 50,
   parameter int              SETTLE_CYCLES = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid_i,
   input  logic [2:0]          req_mode_i,
   input  logic                pll_bypass_i,
   input  logic [NUM_WAKE-1:0] wake_mask_i,
   input  logic [NUM_WAKE-1:0] wake_evt_i,
   input  logic                rtc_irq_i,
   input  logic                rst_pin_i,
   input  logic                dma_l1_req_i,
   input  logic                vr_wr_i,
   input  logic [VR_W-1:0]     vr_wdata_i,
   input  logic [NUM_PADS-1:0] pad_exempt_i,
   output logic [2:0]          mode_o,
   output logic                cclk_en_o,
   output logic                sclk_en_o,
   output logic                vreg_en_o,
   output logic                pll_bypass_o,
   output logic                hw_rst_o,
   output logic [NUM_PADS-1:0] pad_tri_o,
   output logic                dma_err_o,
   output logic [VR_W-1:0]     vr_code_o,
   output logic [MV_W-1:0]     core_mv_o
);

   initial begin
      if (NUM_WAKE < 1 || NUM_PADS < 1) $fatal(1, "pwr_mode_ctrl: need at least one wake source and one pad");
      if (SETTLE_CYCLES < 1) $fatal(1, "pwr_mode_ctrl: settle count must be positive");
      if (MV_W < 2 || BASE_MV + STEP_MV * ((1 << VR_W) - 1) >= (1 << MV_W))
         $fatal(1, "pwr_mode_ctrl: millivolt output too narrow");
   end

   pm_state_e state;
   logic      run;

   pwr_mode_fsm #(
      .NUM_WAKE      (NUM_WAKE),
      .SETTLE_CYCLES (SETTLE_CYCLES)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid_i),
      .req_mode_i   (req_mode_i),
      .pll_bypass_i (pll_bypass_i),
      .wake_mask_i  (wake_mask_i),
      .wake_evt_i   (wake_evt_i),
      .rtc_irq_i    (rtc_irq_i),
      .rst_pin_i    (rst_pin_i),
      .dma_l1_req_i (dma_l1_req_i),
      .state_o      (state),
      .dma_err_o    (dma_err_o)
   );

   assign run = pm_is_run(state);

   pwr_vreg_ctrl #(
      .VR_W     (VR_W),
      .MV_W     (MV_W),
      .VR_RESET (VR_RESET),
      .BASE_MV  (BASE_MV),
      .STEP_MV  (STEP_MV)
   ) u_vreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (vr_wr_i && run),
      .wdata_i (vr_wdata_i),
      .code_o  (vr_code_o),
      .mv_o    (core_mv_o)
   );

   pwr_pad_iso #(
      .NUM_PADS (NUM_PADS)
   ) u_pad (
      .iso_i    (state == PM_HIBER),
      .exempt_i (pad_exempt_i),
      .tri_o    (pad_tri_o)
   );

   assign mode_o       = state;
   assign cclk_en_o    = run;
   assign sclk_en_o    = run || (state == PM_SLEEP);
   assign vreg_en_o    = (state != PM_HIBER);
   assign pll_bypass_o = (state == PM_ACTIVE);
   assign hw_rst_o     = (state == PM_RSTSEQ);

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk #(
   parameter int NUM_WAKE = 4,
   parameter int VR_W     = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid_i,
   input logic                pll_bypass_i,
   input logic [NUM_WAKE-1:0] wake_mask_i,
   input logic [NUM_WAKE-1:0] wake_evt_i,
   input logic                rtc_irq_i,
   input logic                rst_pin_i,
   input logic                dma_l1_req_i,
   input logic [2:0]          mode_o,
   input logic                cclk_en_o,
   input logic                sclk_en_o,
   input logic                vreg_en_o,
   input logic                dma_err_o,
   input logic [VR_W-1:0]     vr_code_o
);

   // R4
   a_r4_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd2 && !rst_pin_i && rtc_irq_i) |=> (mode_o == ($past(pll_bypass_i) ? 3'd1 : 3'd0)));

   // R5
   a_r5_dma_refused: assert property (@(posedge clk) disable iff (!rst_n)
      dma_err_o |-> ($past(mode_o) == 3'd2 && $past(dma_l1_req_i)));

   // R6
   a_r6_dsleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd3 && !rst_pin_i && !rtc_irq_i) |=> (mode_o == 3'd3));

   a_r6_dsleep_pin: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd3 && rst_pin_i) |=> (mode_o == 3'd0));

   // R7
   a_r7_hib_power_off: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4) |-> (!vreg_en_o && !cclk_en_o && !sclk_en_o));

   // R8
   a_r8_hib_exit_path: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd4) |=> (mode_o == 3'd4 || mode_o == 3'd5));

   // R9
   a_r9_seq_exit: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == 3'd5) |=> (mode_o == 3'd5 || mode_o == 3'd0));

   // R10
   a_r10_code_retained: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_o == 3'd0 || mode_o == 3'd1) |=> $stable(vr_code_o));

   // R11
   a_r11_req_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o >= 3'd2 && mode_o <= 3'd4 && req_valid_i && !rst_pin_i && !rtc_irq_i
       && (wake_evt_i & wake_mask_i) == '0) |=> $stable(mode_o));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.NUM_WAKE(NUM_WAKE), .VR_W(VR_W)) u_chk (.*);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;

   localparam int NW = 4;
   localparam int NP = 8;
   localparam int VW = 6;
   localparam int MW = 16;
   localparam int SETTLE = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid_i = 1'b0;
   logic [2:0]    req_mode_i = '0;
   logic          pll_bypass_i = 1'b0;
   logic [NW-1:0] wake_mask_i = '0;
   logic [NW-1:0] wake_evt_i = '0;
   logic          rtc_irq_i = 1'b0;
   logic          rst_pin_i = 1'b0;
   logic          dma_l1_req_i = 1'b0;
   logic          vr_wr_i = 1'b0;
   logic [VW-1:0] vr_wdata_i = '0;
   logic [NP-1:0] pad_exempt_i = '0;
   logic [2:0]    mode_o;
   logic          cclk_en_o, sclk_en_o, vreg_en_o, pll_bypass_o, hw_rst_o, dma_err_o;
   logic [NP-1:0] pad_tri_o;
   logic [VW-1:0] vr_code_o;
   logic [MW-1:0] core_mv_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   pwr_mode_ctrl u_dut (.*);

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // drive one cycle of stimulus, then release; state after the edge is visible on return
   task automatic pulse_req(input logic [2:0] code);
      @(negedge clk); req_valid_i = 1'b1; req_mode_i = code;
      @(negedge clk); req_valid_i = 1'b0;
   endtask

   task automatic pulse_wake(input logic [NW-1:0] evt, input logic rtc, input logic pin);
      @(negedge clk); wake_evt_i = evt; rtc_irq_i = rtc; rst_pin_i = pin;
      @(negedge clk); wake_evt_i = '0; rtc_irq_i = 1'b0; rst_pin_i = 1'b0;
   endtask

   task automatic write_code(input logic [VW-1:0] v);
      @(negedge clk); vr_wr_i = 1'b1; vr_wdata_i = v;
      @(negedge clk); vr_wr_i = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "mode", mode_o, 0);
      chk("R1", "cclk", cclk_en_o, 1);
      chk("R1", "sclk", sclk_en_o, 1);
      chk("R1", "vreg", vreg_en_o, 1);
      chk("R1", "hw_rst", hw_rst_o, 0);
      chk("R1", "pads", pad_tri_o, 0);
      chk("R1", "code", vr_code_o, 20);
      chk("R10", "mv at reset code", core_mv_o, 1700);
   endtask

   task automatic t_run_modes();
      pulse_req(3'd1);
      chk("R2", "to active", mode_o, 1);
      chk("R2", "bypass out in active", pll_bypass_o, 1);
      pulse_req(3'd6);
      chk("R2", "code 6 ignored", mode_o, 1);
      pulse_req(3'd0);
      chk("R2", "to full-on", mode_o, 0);
      chk("R2", "bypass out in full-on", pll_bypass_o, 0);
   endtask

   task automatic t_sleep();
      wake_mask_i = 4'b0001;
      pulse_req(3'd2);
      chk("R3", "mode sleep", mode_o, 2);
      chk("R3", "cclk off", cclk_en_o, 0);
      chk("R3", "sclk on", sclk_en_o, 1);
      chk("R3", "vreg on", vreg_en_o, 1);
      @(negedge clk); dma_l1_req_i = 1'b1;
      @(negedge clk); dma_l1_req_i = 1'b0;
      chk("R5", "dma error in sleep", dma_err_o, 1);
      pulse_req(3'd0);
      chk("R11", "request in sleep ignored", mode_o, 2);
      pulse_wake(4'b0010, 1'b0, 1'b0);
      chk("R4", "masked event ignored", mode_o, 2);
      pll_bypass_i = 1'b1;
      pulse_wake(4'b0001, 1'b0, 1'b0);
      chk("R4", "enabled wake with bypass", mode_o, 1);
      pll_bypass_i = 1'b0;
      pulse_req(3'd2);
      pulse_wake(4'b0000, 1'b1, 1'b0);
      chk("R4", "rtc wake without bypass", mode_o, 0);
      @(negedge clk); dma_l1_req_i = 1'b1;
      @(negedge clk); dma_l1_req_i = 1'b0;
      chk("R5", "no dma error in full-on", dma_err_o, 0);
   endtask

   task automatic t_dsleep();
      wake_mask_i = 4'b1111;
      pulse_req(3'd3);
      chk("R6", "mode deep sleep", mode_o, 3);
      chk("R6", "cclk off", cclk_en_o, 0);
      chk("R6", "sclk off", sclk_en_o, 0);
      pulse_wake(4'b1111, 1'b0, 1'b0);
      chk("R6", "peripheral wake ignored", mode_o, 3);
      pulse_req(3'd1);
      chk("R11", "request in deep sleep ignored", mode_o, 3);
      pulse_wake(4'b0000, 1'b1, 1'b0);
      chk("R6", "rtc to active", mode_o, 1);
      pulse_req(3'd3);
      pulse_wake(4'b0000, 1'b1, 1'b1);
      chk("R6", "reset pin beats rtc", mode_o, 0);
   endtask

   task automatic t_hiber_evt();
      write_code(6'd10);
      chk("R10", "code written", vr_code_o, 10);
      chk("R10", "mv 700+50*10", core_mv_o, 1200);
      wake_mask_i = 4'b0100;
      pad_exempt_i = 8'b1010_0101;
      pulse_req(3'd4);
      chk("R7", "mode hibernate", mode_o, 4);
      chk("R7", "vreg off", vreg_en_o, 0);
      chk("R7", "clocks off", {30'd0, cclk_en_o, sclk_en_o}, 0);
      chk("R7", "pads three-stated", pad_tri_o, 8'b0101_1010);
      write_code(6'd33);
      chk("R10", "write in hibernate ignored", vr_code_o, 10);
      pulse_req(3'd0);
      chk("R11", "request in hibernate ignored", mode_o, 4);
      pulse_wake(4'b1011, 1'b0, 1'b0);
      chk("R8", "masked event ignored", mode_o, 4);
      pulse_wake(4'b0100, 1'b0, 1'b0);
      chk("R8", "enabled event starts sequence", mode_o, 5);
      chk("R9", "hw reset high", hw_rst_o, 1);
      chk("R9", "vreg on in sequence", vreg_en_o, 1);
      chk("R9", "clocks off in sequence", {30'd0, cclk_en_o, sclk_en_o}, 0);
      chk("R7", "pads released", pad_tri_o, 0);
      for (int i = 1; i < SETTLE; i++) @(negedge clk);
      chk("R9", "still in sequence at last cycle", mode_o, 5);
      @(negedge clk);
      chk("R9", "full-on after settle", mode_o, 0);
      chk("R9", "hw reset released", hw_rst_o, 0);
      chk("R10", "code kept across hibernate", vr_code_o, 10);
   endtask

   task automatic t_hiber_rtc_pin();
      pulse_req(3'd4);
      pulse_wake(4'b0000, 1'b1, 1'b0);
      chk("R8", "rtc exits to sequence", mode_o, 5);
      repeat (SETTLE) @(negedge clk);
      chk("R9", "full-on after rtc exit", mode_o, 0);
      pulse_req(3'd4);
      pulse_wake(4'b0000, 1'b0, 1'b1);
      chk("R8", "reset pin exits to sequence", mode_o, 5);
      repeat (SETTLE) @(negedge clk);
      chk("R9", "full-on after pin exit", mode_o, 0);
   endtask

   task automatic t_rst_pin();
      pulse_req(3'd1);
      pulse_wake(4'b0000, 1'b0, 1'b1);
      chk("R12", "pin in active", mode_o, 0);
      pulse_req(3'd2);
      pll_bypass_i = 1'b1;
      pulse_wake(4'b0000, 1'b0, 1'b1);
      pll_bypass_i = 1'b0;
      chk("R12", "pin in sleep", mode_o, 0);
      chk("R10", "code kept across pin reset", vr_code_o, 10);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_run_modes();
      t_sleep();
      t_dsleep();
      t_hiber_evt();
      t_hiber_rtc_pin();
      t_rst_pin();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule